// File: doc/BRIEF.md
# Receiver Enable Seed Calculator

This block works out, for each byte lane of one memory rank, the starting delay that a read-capture receiver-enable circuit is loaded with before hardware-assisted training runs. Delays are counted in 1/32 of a unit interval (UI). The training circuit cannot reach very long delays, so each seed is split in two parts. The first is a short value that is programmed: the 5-bit fine part plus a 2-bit coarse step that is either one or two UI. The second is a remainder of whole UIs. That remainder is stored in a 16-bit result slot and is added back once training has finished.

There are two ways to source the seed. In the first pass, the lane's write-levelling delay is used with a fixed offset added. In the second pass, the lane's earlier receiver-enable result is used, moved back by one UI and rescaled from the previous memory clock speed to the current one. A one-cycle `start` launches a sweep over all lanes. The first pass produces one lane per clock. The second pass runs every lane through a shared bit-serial divider. Each lane result is given with a valid strobe and its lane number.

Top module: `rxen_seed_calc`

## Requirements
- R1: In the first pass (`pass2_sel`=0), a lane's seed is its source delay plus 0x3B, taken modulo 2^16.
- R2: In the second pass (`pass2_sel`=1), a lane's seed is found in three steps. First, ((source − 0x20) mod 2^16) is multiplied by `cur_speed`. Second, the product is divided by `prev_speed` with truncation. Third, the quotient is kept modulo 2^16.
- R3: When seed bit 5 is 1 (odd coarse count), `lane_seed` is {2'b01, seed[4:0]}.
- R4: When seed bit 5 is 0 (even coarse count), `lane_seed` is {2'b10, seed[4:0]}.
- R5: `lane_slot` equals (((seed & 0x1E0) − (bit 5 set ? 0x20 : 0x40)) mod 2^16) shifted left by 6, taken modulo 2^16.
- R6: A sweep emits lanes 0 to LANES−1 in ascending order. Each lane has one `lane_vld` cycle. In the first pass, lane k is valid k+1 cycles after the clock edge that accepted `start`.
- R7: In the second pass, lane k is valid (k+1)·(DLY_W+SPD_W+1) cycles after the accepting edge. This is 28 cycles per lane at the default parameters.
- R8: `busy` is high from the accepting edge until the edge that emits the last lane. `done` is a one-cycle pulse that arrives in the same cycle as the last lane's `lane_vld`.
- R9: A second pass with `prev_speed`=0 gives a seed of 0 for every lane, which means `lane_seed`=0x40 and `lane_slot`=0xF000. In that case `div_err` is high from the accepting edge until the next accepted `start`. Any other accepted start clears `div_err`.
- R10: A `start` pulse while `busy` is high is ignored. It does not change the timing or the values of the sweep already running.
- R11: After reset, `busy`, `done`, `lane_vld` and `div_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a sweep when idle |
| pass2_sel | input | 1 | 0 = write-levelling source, 1 = rescaled earlier result |
| cur_speed | input | SPD_W | Current clock speed, sampled at start |
| prev_speed | input | SPD_W | Previous clock speed, sampled at start |
| src_dly | input | LANES*DLY_W | Per-lane source delay, lane k at bits [k*DLY_W +: DLY_W], held stable while busy |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Pulse with the last lane |
| lane_vld | output | 1 | Lane result valid |
| lane_idx | output | $clog2(LANES) | Lane number of the result |
| lane_seed | output | 7 | Programmed seed {coarse step, fine} |
| lane_slot | output | 16 | Remainder shifted into the result slot |
| div_err | output | 1 | Zero previous speed seen in a second pass |

## Verification
The first pass is driven with lane delays chosen to cover four cases: odd and even coarse counts, a zero delay, and a delay that wraps past 2^16. These cases separate the two pre-gross encodings and show both the wrapped remainder of an even count below 0x40 and the modulo addition. The second pass is run with speed ratios above and below one, so truncation in both directions is checked, and with a source below one UI, which tests the wrapped subtraction feeding the divider. A zero previous speed shows that the forced-zero seed and the error flag are raised and later cleared. A `start` issued in the middle of a sweep shows that the lane schedule, which the bench follows on every clock, is left as it was.

// File: rtl/rxen_seed_pkg.sv
package rxen_seed_pkg;
  localparam int SEED_W    = 16;
  localparam int FINE_W    = 5;
  localparam int PROG_W    = FINE_W + 2;
  localparam int SLOT_SH   = 6;
  localparam int ONE_UI    = 32;
  localparam int PASS1_OFS = 59;

  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_WAIT} seed_st_t;

  // Programmed value: coarse step 1 (odd gross) or 2 (even gross) over fine bits
  function automatic logic [PROG_W-1:0] prog_of(input logic [SEED_W-1:0] s);
    logic [1:0] step;
    step = s[FINE_W] ? 2'b01 : 2'b10;
    return {step, s[FINE_W-1:0]};
  endfunction

  // Whole-UI remainder left after the coarse step, placed into the result slot
  function automatic logic [SEED_W-1:0] slot_of(input logic [SEED_W-1:0] s);
    logic [SEED_W-1:0] gross, rem;
    gross = s & SEED_W'(16'h01E0);
    rem   = gross - (s[FINE_W] ? SEED_W'(ONE_UI) : SEED_W'(2 * ONE_UI));
    return rem << SLOT_SH;
  endfunction
endpackage

// File: rtl/rxen_seq_div.sv
module rxen_seq_div #(
  parameter int NW = 27,
  parameter int DW = 11,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [OW-1:0] quo,
  output logic          rdy
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q;
  logic [DW-1:0] r;
  logic [DW-1:0] d;
  logic [CW-1:0] cnt;
  logic [DW:0]   trial;
  logic          fits;

  assign trial = {r, q[NW-1]};
  assign fits  = trial >= {1'b0, d};
  assign quo   = q[OW-1:0];
  assign rdy   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      r   <= '0;
      d   <= '0;
      cnt <= '0;
    end else if (load) begin
      q   <= num;
      r   <= '0;
      d   <= den;
      cnt <= CW'(NW);
    end else if (cnt != '0) begin
      if (fits) r <= DW'(trial - {1'b0, d});
      else      r <= DW'(trial);
      q   <= {q[NW-2:0], fits};
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/rxen_seed_split.sv
module rxen_seed_split
  import rxen_seed_pkg::*;
(
  input  logic [SEED_W-1:0] seed,
  output logic [PROG_W-1:0] prog,
  output logic [SEED_W-1:0] slot
);
  assign prog = prog_of(seed);
  assign slot = slot_of(seed);
endmodule

// File: rtl/rxen_seed_calc.sv
module rxen_seed_calc
  import rxen_seed_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DLY_W = 16,
  parameter int SPD_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       pass2_sel,
  input  logic [SPD_W-1:0]           cur_speed,
  input  logic [SPD_W-1:0]           prev_speed,
  input  logic [LANES*DLY_W-1:0]     src_dly,
  output logic                       busy,
  output logic                       done,
  output logic                       lane_vld,
  output logic [$clog2(LANES)-1:0]   lane_idx,
  output logic [PROG_W-1:0]          lane_seed,
  output logic [SEED_W-1:0]          lane_slot,
  output logic                       div_err
);
  localparam int LIDX_W = $clog2(LANES);
  localparam int PW     = DLY_W + SPD_W;

  seed_st_t          state;
  logic [LIDX_W-1:0] lane_i, ld_idx;
  logic [SPD_W-1:0]  cur_q, prev_q, spd_sel, den_sel;
  logic              err_q;

  // named internal events
  logic              idle, accept, emit_now, last_lane, div_load, div_rdy;
  logic [DLY_W-1:0]  src_ld, src_cur, diff, quo, seed_raw;
  logic [PW-1:0]     num;
  logic [PROG_W-1:0] prog;
  logic [SEED_W-1:0] slot;

  always_comb begin
    idle      = (state == ST_IDLE);
    accept    = idle && start;
    ld_idx    = idle ? '0 : lane_i + LIDX_W'(1);
    spd_sel   = idle ? cur_speed  : cur_q;
    den_sel   = idle ? prev_speed : prev_q;
    last_lane = (lane_i == LIDX_W'(LANES - 1));
    emit_now  = (state == ST_STEP) || (state == ST_WAIT && div_rdy);
    div_load  = (accept && pass2_sel) || (state == ST_WAIT && div_rdy && !last_lane);
    src_ld    = src_dly[DLY_W*int'(ld_idx) +: DLY_W];
    src_cur   = src_dly[DLY_W*int'(lane_i) +: DLY_W];
    diff      = src_ld - DLY_W'(ONE_UI);
    num       = PW'(diff) * PW'(spd_sel);
    seed_raw  = (state == ST_STEP) ? src_cur + DLY_W'(PASS1_OFS)
                                   : (err_q ? '0 : quo);
  end

  rxen_seq_div #(.NW(PW), .DW(SPD_W), .OW(DLY_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (div_load),
    .num   (num),
    .den   (den_sel),
    .quo   (quo),
    .rdy   (div_rdy)
  );

  rxen_seed_split u_split (
    .seed (SEED_W'(seed_raw)),
    .prog (prog),
    .slot (slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lane_i    <= '0;
      cur_q     <= '0;
      prev_q    <= '0;
      err_q     <= 1'b0;
      lane_vld  <= 1'b0;
      done      <= 1'b0;
      lane_idx  <= '0;
      lane_seed <= '0;
      lane_slot <= '0;
    end else begin
      lane_vld <= emit_now;
      done     <= emit_now && last_lane;
      if (accept) begin
        state  <= pass2_sel ? ST_WAIT : ST_STEP;
        lane_i <= '0;
        cur_q  <= cur_speed;
        prev_q <= prev_speed;
        err_q  <= pass2_sel && (prev_speed == '0);
      end
      if (emit_now) begin
        lane_idx  <= lane_i;
        lane_seed <= prog;
        lane_slot <= slot;
        if (last_lane) begin
          state  <= ST_IDLE;
          lane_i <= '0;
        end else begin
          lane_i <= lane_i + LIDX_W'(1);
        end
      end
    end
  end

  assign busy    = !idle;
  assign div_err = err_q;
endmodule

// File: rtl/rxen_seed_calc_chk.sv
module rxen_seed_calc_chk #(
  parameter int LANES  = 8,
  parameter int LIDX_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              lane_vld,
  input logic [LIDX_W-1:0] lane_idx,
  input logic [6:0]        lane_seed,
  input logic [15:0]       lane_slot,
  input logic              div_err,
  input logic              emit_now
);
  a_r8_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lane_vld && lane_idx == LIDX_W'(LANES - 1)));

  a_r8_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r3_pregross_code: assert property (@(posedge clk) disable iff (!rst_n)
    lane_vld |-> (lane_seed[6] ^ lane_seed[5]));

  a_r5_slot_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    lane_vld |-> (lane_slot[5:0] == 6'd0));

  a_r9_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld && div_err) |-> (lane_seed == 7'h40 && lane_slot == 16'hF000));

  a_r6_emit_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    emit_now |=> lane_vld);

  a_r10_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_err));
endmodule

bind rxen_seed_calc rxen_seed_calc_chk #(.LANES(LANES), .LIDX_W(LIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .lane_vld  (lane_vld),
  .lane_idx  (lane_idx),
  .lane_seed (lane_seed),
  .lane_slot (lane_slot),
  .div_err   (div_err),
  .emit_now  (emit_now)
);

// File: tb/rxen_seed_calc_bench.sv
`timescale 1ns/1ps
module rxen_seed_calc_bench;
  localparam int LANES = 8;
  localparam int DW    = 16;
  localparam int SW    = 11;
  localparam int P2PER = DW + SW + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              pass2_sel = 1'b0;
  logic [SW-1:0]     cur_speed = '0;
  logic [SW-1:0]     prev_speed = '0;
  logic [LANES*DW-1:0] src_bus;
  logic [DW-1:0]     lane_src [LANES];
  logic              busy, done, lane_vld, div_err;
  logic [2:0]        lane_idx;
  logic [6:0]        lane_seed;
  logic [15:0]       lane_slot;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  for (genvar k = 0; k < LANES; k++) begin : g_pack
    assign src_bus[k*DW +: DW] = lane_src[k];
  end

  rxen_seed_calc u_rxen_seed_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .pass2_sel(pass2_sel),
    .cur_speed(cur_speed), .prev_speed(prev_speed), .src_dly(src_bus),
    .busy(busy), .done(done), .lane_vld(lane_vld), .lane_idx(lane_idx),
    .lane_seed(lane_seed), .lane_slot(lane_slot), .div_err(div_err)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic longint ref_seed(input bit p2, input longint src, input longint cur, input longint prev);
    if (!p2) return (src + 59) % 65536;
    if (prev == 0) return 0;
    return ((((src - 32) % 65536 + 65536) % 65536 * cur) / prev) % 65536;
  endfunction

  task automatic run(input bit p2, input int cur, input int prev, input bit poke);
    int per, last;
    per  = p2 ? P2PER : 1;
    last = LANES * per;
    @(negedge clk);
    start = 1'b1; pass2_sel = p2; cur_speed = SW'(cur); prev_speed = SW'(prev);
    for (int n = 0; n <= last + 2; n++) begin
      bit ev;
      @(negedge clk);
      start = poke && (n == 2);   // R10: extra start while busy
      ev = (n >= per) && (n % per == 0) && (n <= last);
      chk(p2 ? "R7" : "R6", "lane_vld", lane_vld, ev);
      chk("R8", "busy", busy, n < last);
      chk("R8", "done", done, n == last);
      chk("R9", "div_err", div_err, p2 && prev == 0);
      if (ev && lane_vld) begin
        longint s, pg, ex_prog, rem;
        int k;
        k = n / per - 1;
        s = ref_seed(p2, lane_src[k], cur, prev);
        pg = (s / 32) % 2 == 1 ? 1 : 2;
        ex_prog = pg * 32 + s % 32;
        rem = ((s / 32 % 16) * 32 - pg * 32 + 65536) % 65536;
        chk("R6", "lane_idx", lane_idx, k);
        chk(p2 ? "R2" : "R1", "seed fine", lane_seed[4:0], s % 32);
        chk(pg == 1 ? "R3" : "R4", "coarse step", lane_seed[6:5], pg);
        chk("R5", "slot", lane_slot, (rem * 64) % 65536);
        if (poke) chk("R10", "seed", lane_seed, ex_prog);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < LANES; k++) lane_src[k] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "busy", busy, 0);
    chk("R11", "lane_vld", lane_vld, 0);
    chk("R11", "done", done, 0);
    chk("R11", "div_err", div_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 with odd/even gross, zero, wrap past 2^16; R10 poke mid-sweep
    lane_src[0] = 16'h0000; lane_src[1] = 16'h0005; lane_src[2] = 16'h0020;
    lane_src[3] = 16'h003F; lane_src[4] = 16'h0100; lane_src[5] = 16'h01A5;
    lane_src[6] = 16'hFFD0; lane_src[7] = 16'h00C4;
    run(1'b0, 0, 0, 1'b1);
    // R2: ratio above one, including a source below one UI
    lane_src[0] = 16'h0010; lane_src[1] = 16'h0040; lane_src[2] = 16'h0077;
    lane_src[3] = 16'h00A3; lane_src[4] = 16'h0120; lane_src[5] = 16'h0155;
    lane_src[6] = 16'h01F0; lane_src[7] = 16'h0033;
    run(1'b1, 1066, 800, 1'b0);
    // R2: ratio below one
    run(1'b1, 667, 1333, 1'b0);
    // R9: zero previous speed
    run(1'b1, 1600, 0, 1'b0);
    // R9: flag cleared by next start
    run(1'b0, 0, 0, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule